// File: doc/BRIEF.md
# Reset-Pulse Identification Word Streamer

This block sits beside the serial command controller of a secure serial memory. When the host raises and then lowers the reset pin while the chip is selected (select is active low), and no nonvolatile write is under way, the block takes over the data line. It shifts out a fixed 32-bit identification word one bit per serial clock, least significant bit first. The word is set by a parameter when the block is built, and no bus command can change it.

All pins are sampled in the block's own clock domain through a synchronizer. The block advances the word on the falling edges of the serial clock, so the host can sample each bit on the rising edge. Once the last bit has been clocked out, the block releases the data line and raises a one-cycle completion pulse. If select goes high at any point, the block releases the line at once and raises a one-cycle abort pulse instead. Either pulse tells the main controller to return to standby. While the block is armed or streaming, `active_o` tells the main controller to ignore serial traffic.

Top module: `reset_id_streamer`

## Requirements
- R1: After `rst_ni` is released, `sda_oe_o`, `active_o`, `done_o` and `abort_o` are all 0, and `sda_o` is 1.
- R2: A rising edge on `rst_pin_i` while `cs_ni` is 0 and `wr_busy_i` is 0 arms the block: `active_o` goes to 1 while `sda_oe_o` stays 0. When the pin then falls, `sda_oe_o` goes to 1 and `sda_o` shows bit 0 of `ID_WORD`.
- R3: Each falling edge of `scl_i` during streaming moves `sda_o` to the next higher bit of `ID_WORD`. A rising edge of `scl_i` leaves `sda_o` unchanged.
- R4: On the 32nd falling edge of `scl_i` after streaming began, `sda_oe_o` and `active_o` return to 0 and `done_o` is 1 for exactly one clock.
- R5: A reset-pin pulse while `wr_busy_i` is 1 does not start a stream: `active_o` and `sda_oe_o` stay 0.
- R6: A reset-pin pulse while `cs_ni` is 1 does not start a stream.
- R7: `cs_ni` going to 1 while the block is armed or streaming ends the sequence. `sda_oe_o` and `active_o` fall, `abort_o` is 1 for exactly one clock, and `done_o` stays 0. Serial clocks that follow have no effect.
- R8: While idle, toggling `scl_i` leaves `sda_oe_o` at 0 and `sda_o` at 1.
- R9: A second reset-pin pulse during streaming neither restarts nor disturbs the word: the current bit holds and the sequence continues.
- R10: After a completed stream, a new reset-pin pulse streams the whole word again, starting from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all pins are oversampled with it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select pin, active low |
| rst_pin_i | input | 1 | Reset pin that triggers the identification stream |
| scl_i | input | 1 | Serial clock pin |
| wr_busy_i | input | 1 | Nonvolatile write in progress, from the write engine |
| sda_o | output | 1 | Data bit for the pad; 1 when not driving |
| sda_oe_o | output | 1 | Pad drive enable; 0 leaves the line to the serial controller |
| active_o | output | 1 | Block is armed or streaming; the controller ignores bus traffic |
| done_o | output | 1 | One-cycle pulse when the last bit has been sent |
| abort_o | output | 1 | One-cycle pulse when chip select ends the sequence early |

## Verification
The whole word is streamed with a non-symmetric constant, so a bit-order or off-by-one fault shows as a wrong value at a known bit index. At each step the serial clock's rising and falling halves are checked separately, which tells an advance on the wrong edge from a correct one. Trigger pulses are also given with select high, with the write engine busy, and in the middle of a stream, to separate a wrong start condition from an unwanted restart. Select is raised both while armed and mid-word, and scl is then toggled, to tell a clean abort from a leaked completion or a stream that resumes.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STREAM = 2'd2
  } rid_state_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_TRIG = 1;
  localparam int unsigned PIN_SCL  = 2;
  localparam int unsigned PIN_BUSY = 3;
  localparam int unsigned PIN_W    = 4;
  // select idles deasserted (high)
  localparam logic [PIN_W-1:0] PIN_RST_VAL = 4'b0001;
endpackage

// File: rtl/rid_sync.sv
module rid_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rid_edge.sv
module rid_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  if (RISING) begin : g_rise
    assign edge_o = lvl_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~lvl_i & prev_q;
  end
endmodule

// File: rtl/rid_shifter.sv
module rid_shifter #(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] ID_WORD = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  output logic bit_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= ID_WORD;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (cnt_q == CNT_LAST);

  // sequencer must finish on the last bit, never shift past it
  assert_no_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (cnt_q != CNT_LAST));
endmodule

// File: rtl/rid_fsm.sv
module rid_fsm
  import rid_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_hi_i,
  input  logic busy_i,
  input  logic trig_rise_i,
  input  logic trig_fall_i,
  input  logic scl_fall_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic drive_o,
  output logic active_o,
  output logic done_o,
  output logic abort_o
);
  rid_state_e state_q, state_d;
  logic done_d, abort_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    done_d  = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_rise_i && !cs_hi_i && !busy_i) begin
          state_d = ST_ARMED;
          load_o  = 1'b1;
        end
      end
      ST_ARMED: begin
        if (cs_hi_i) begin
          state_d = ST_IDLE;
          abort_d = 1'b1;
        end else if (trig_fall_i) begin
          state_d = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (cs_hi_i) begin
          state_d = ST_IDLE;
          abort_d = 1'b1;
        end else if (scl_fall_i) begin
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            shift_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      abort_o <= abort_d;
    end
  end

  assign drive_o  = (state_q == ST_STREAM);
  assign active_o = (state_q != ST_IDLE);

  assert_no_skip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q != ST_STREAM));

  assert_busy_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && busy_i) |=> (state_q == ST_IDLE));

  assert_deselect_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hi_i |=> (state_q == ST_IDLE));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_abort_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && abort_o));
endmodule

// File: rtl/reset_id_streamer.sv
module reset_id_streamer #(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] ID_WORD = 32'hA5C3_1E92,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rst_pin_i,
  input  logic scl_i,
  input  logic wr_busy_i,
  output logic sda_o,
  output logic sda_oe_o,
  output logic active_o,
  output logic done_o,
  output logic abort_o
);
  import rid_pkg::*;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic trig_rise, trig_fall, scl_fall;
  logic load, shift, last, data_bit, drive;

  assign pins_raw[PIN_CS]   = cs_ni;
  assign pins_raw[PIN_TRIG] = rst_pin_i;
  assign pins_raw[PIN_SCL]  = scl_i;
  assign pins_raw[PIN_BUSY] = wr_busy_i;

  rid_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST_VAL)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_raw), .q_o(pins_s)
  );

  rid_edge #(.RISING(1'b1)) u_trig_rise (
    .clk_i, .rst_ni, .lvl_i(pins_s[PIN_TRIG]), .edge_o(trig_rise)
  );
  rid_edge #(.RISING(1'b0)) u_trig_fall (
    .clk_i, .rst_ni, .lvl_i(pins_s[PIN_TRIG]), .edge_o(trig_fall)
  );
  rid_edge #(.RISING(1'b0)) u_scl_fall (
    .clk_i, .rst_ni, .lvl_i(pins_s[PIN_SCL]), .edge_o(scl_fall)
  );

  rid_fsm u_fsm (
    .clk_i, .rst_ni,
    .cs_hi_i(pins_s[PIN_CS]), .busy_i(pins_s[PIN_BUSY]),
    .trig_rise_i(trig_rise), .trig_fall_i(trig_fall),
    .scl_fall_i(scl_fall), .last_i(last),
    .load_o(load), .shift_o(shift), .drive_o(drive),
    .active_o, .done_o, .abort_o
  );

  rid_shifter #(.WORD_W(WORD_W), .ID_WORD(ID_WORD)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .bit_o(data_bit), .last_o(last)
  );

  assign sda_oe_o = drive;
  assign sda_o    = drive ? data_bit : 1'b1;

  // released line must read high (idle level for the open-drain pad)
  assert_release_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_oe_o |-> sda_o);
endmodule

// File: tb/reset_id_streamer_tb.sv
module reset_id_streamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;
  localparam logic [31:0] ID = 32'hA5C3_1E92;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, pin = 1'b0, scl = 1'b0, busy = 1'b0;
  logic sda, oe, act, done, abrt;
  int errors = 0, checks = 0, done_cnt = 0, abort_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_id_streamer #(.WORD_W(32), .ID_WORD(ID), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rst_pin_i(pin), .scl_i(scl),
    .wr_busy_i(busy), .sda_o(sda), .sda_oe_o(oe), .active_o(act),
    .done_o(done), .abort_o(abrt)
  );

  always @(posedge clk) begin
    if (done) done_cnt++;
    if (abrt) abort_cnt++;
  end

  task automatic chk(input string req, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_pin();
    pin = 1'b1; settle();
    pin = 1'b0; settle();
  endtask

  task automatic t_reset();
    chk("R1", "oe", oe, 0);
    chk("R1", "active", act, 0);
    chk("R1", "done", done, 0);
    chk("R1", "abort", abrt, 0);
    chk("R1", "sda", sda, 1);
  endtask

  task automatic t_full_stream(input bit inject, input string tag);
    int d0 = done_cnt;
    cs_n = 1'b0; settle();
    pin = 1'b1; settle();
    chk("R2", "armed active", act, 1);
    chk("R2", "armed oe", oe, 0);
    pin = 1'b0; settle();
    chk("R2", "oe after fall", oe, 1);
    chk(tag, "bit0", sda, int'(ID[0]));
    for (int k = 1; k < 32; k++) begin
      if (inject && k == 10) begin
        pulse_pin();
        chk("R9", "bit held after repulse", sda, int'(ID[k-1]));
        chk("R9", "oe held after repulse", oe, 1);
      end
      scl = 1'b1; settle();
      chk("R3", "rising holds bit", sda, int'(ID[k-1]));
      scl = 1'b0; settle();
      chk(tag, $sformatf("bit%0d", k), sda, int'(ID[k]));
    end
    scl = 1'b1; settle();
    chk("R3", "bit31 held", sda, int'(ID[31]));
    chk("R4", "oe before last fall", oe, 1);
    scl = 1'b0; settle();
    chk("R4", "oe released", oe, 0);
    chk("R4", "active cleared", act, 0);
    chk("R4", "done pulses", done_cnt - d0, 1);
    chk("R4", "done low", done, 0);
    chk("R4", "sda released", sda, 1);
    cs_n = 1'b1; settle();
  endtask

  task automatic t_busy();
    cs_n = 1'b0; busy = 1'b1; settle();
    pin = 1'b1; settle();
    chk("R5", "active while busy", act, 0);
    pin = 1'b0; settle();
    chk("R5", "oe while busy", oe, 0);
    busy = 1'b0; settle();
    chk("R5", "no late start", act, 0);
    cs_n = 1'b1; settle();
  endtask

  task automatic t_cs_high();
    cs_n = 1'b1; settle();
    pin = 1'b1; settle();
    chk("R6", "active deselected", act, 0);
    pin = 1'b0; settle();
    chk("R6", "oe deselected", oe, 0);
  endtask

  task automatic t_abort_mid();
    int a0 = abort_cnt, d0 = done_cnt;
    cs_n = 1'b0; settle();
    pulse_pin();
    for (int k = 1; k <= 5; k++) begin
      scl = 1'b1; settle();
      scl = 1'b0; settle();
    end
    chk("R7", "bit5 before abort", sda, int'(ID[5]));
    cs_n = 1'b1; settle();
    chk("R7", "oe after abort", oe, 0);
    chk("R7", "active after abort", act, 0);
    chk("R7", "abort pulses", abort_cnt - a0, 1);
    cs_n = 1'b0; settle();
    for (int k = 0; k < 4; k++) begin
      scl = 1'b1; settle();
      scl = 1'b0; settle();
    end
    chk("R7", "no resume oe", oe, 0);
    chk("R7", "no done", done_cnt - d0, 0);
    cs_n = 1'b1; settle();
  endtask

  task automatic t_abort_armed();
    int a0 = abort_cnt;
    cs_n = 1'b0; settle();
    pin = 1'b1; settle();
    chk("R7", "armed", act, 1);
    cs_n = 1'b1; settle();
    chk("R7", "armed abort pulses", abort_cnt - a0, 1);
    pin = 1'b0; settle();
    chk("R7", "no stream after armed abort", oe, 0);
  endtask

  task automatic t_idle_traffic();
    cs_n = 1'b0; settle();
    for (int k = 0; k < 8; k++) begin
      scl = 1'b1; settle();
      chk("R8", "oe idle scl high", oe, 0);
      scl = 1'b0; settle();
      chk("R8", "sda idle", sda, 1);
    end
    cs_n = 1'b1; settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_idle_traffic();
    t_full_stream(1'b0, "R3");
    t_full_stream(1'b0, "R10");
    t_busy();
    t_cs_high();
    t_abort_mid();
    t_abort_armed();
    t_full_stream(1'b1, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule